// File: doc/BRIEF.md
# PHY Power-Up Reset Sequencer

This block brings a serial-link PHY and the controller core attached to it out of reset in a fixed, timed order. From its held state it has the PHY test power-down and the core soft reset asserted, with the reference clock gated. A start request then walks it through the release steps:

- lift power-down;
- after a short gap, enable the reference clock, so the internally synchronised reset lasts long enough;
- let the clocks settle;
- pulse the external endpoint reset pin;
- release the PHY reset;
- poll the PLL lock input a bounded number of times;
- release the core soft reset;
- after a final settling wait, report ready.

Every wait counts pulses of a one-microsecond tick input, and each wait length is a parameter. Each parameter defaults to the shortest legal value of its window. A power-down request returns all outputs to the held state on the next clock edge, whatever step the block is in. The endpoint reset pin's active level is chosen by a parameter.

Top module: `phy_pwrup_seq`

## Requirements
- R1: During and right after reset the outputs are in the held state: phy_test_pd=1, core_rst=1, refclk_en=0, phy_rst=1, endpoint reset at its inactive level, ready=0, busy=0, lock_err=0.
- R2: A start in the held state lowers phy_test_pd and raises busy at the next clock edge. refclk_en rises exactly PD_TO_REFCLK_US ticks later.
- R3: The endpoint reset pin goes to its active level exactly CLK_SETTLE_US ticks after refclk_en rises.
- R4: The endpoint reset stays active for exactly EP_HOLD_US ticks. It returns to inactive on the same edge on which phy_rst falls. The active level is 1 when EP_ACTIVE_HIGH=1 and 0 when it is 0.
- R5: After phy_rst falls, pll_locked is sampled once every LOCK_POLL_GAP_US ticks. core_rst falls at the first sample that sees it high, which is k*LOCK_POLL_GAP_US ticks after the PHY release at the k-th sample.
- R6: If none of LOCK_POLL_MAX samples sees lock, lock_err rises and busy falls at the last sample, with core_rst still high. lock_err then holds until power-down.
- R7: ready rises and busy falls exactly CORE_SETTLE_US ticks after core_rst falls.
- R8: pwr_dn high at any clock edge puts every output in the held state at that edge. It has priority over start.
- R9: start is ignored outside the held state: it neither disturbs a sequence in progress nor leaves the ready or error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse per microsecond; all waits count it |
| start | input | 1 | Begin the release sequence (held state only) |
| pwr_dn | input | 1 | Return to held state |
| pll_locked | input | 1 | PHY PLL lock indication |
| phy_test_pd | output | 1 | PHY test power-down |
| core_rst | output | 1 | Controller core soft reset |
| refclk_en | output | 1 | Reference clock enable |
| phy_rst | output | 1 | PHY reset |
| ep_rst | output | 1 | Endpoint reset pin, polarity per EP_ACTIVE_HIGH |
| ready | output | 1 | Sequence complete |
| busy | output | 1 | Sequence in progress |
| lock_err | output | 1 | PLL never locked within the poll budget |

## Verification
A wrong state or counter value shows directly at the pins. A step skipped or repeated moves one of the output edges by a whole wait length, so the measured tick distance between consecutive output edges is off at the very next edge. A poll counter that is off by one moves the core release or the timeout by one poll gap, and both a miscounted lock threshold and the timeout case are swept to expose it. A broken power-down path leaves some output out of the held state one clock after the request.

// File: rtl/phy_pwrup_pkg.sv
package phy_pwrup_pkg;

    typedef enum logic [2:0] {
        SQ_HOLD  = 3'd0,
        SQ_PWRUP = 3'd1,
        SQ_CLKON = 3'd2,
        SQ_EPRST = 3'd3,
        SQ_LOCK  = 3'd4,
        SQ_CORE  = 3'd5,
        SQ_READY = 3'd6,
        SQ_FAIL  = 3'd7
    } sq_state_e;

    typedef struct packed {
        sq_state_e st;
        logic      test_pd;
        logic      core_rst;
        logic      refclk_en;
        logic      phy_rst;
        logic      ep_act;
        logic      ready;
        logic      busy;
        logic      err;
    } sq_regs_t;

    // Output image of each state; outputs are registered together with the state.
    function automatic sq_regs_t sq_decode(sq_state_e s);
        sq_regs_t r;
        r.st        = s;
        r.test_pd   = 1'b1;
        r.core_rst  = 1'b1;
        r.refclk_en = 1'b0;
        r.phy_rst   = 1'b1;
        r.ep_act    = 1'b0;
        r.ready     = 1'b0;
        r.busy      = 1'b0;
        r.err       = 1'b0;
        case (s)
            SQ_PWRUP: begin
                r.test_pd = 1'b0;
                r.busy    = 1'b1;
            end
            SQ_CLKON: begin
                r.test_pd   = 1'b0;
                r.refclk_en = 1'b1;
                r.busy      = 1'b1;
            end
            SQ_EPRST: begin
                r.test_pd   = 1'b0;
                r.refclk_en = 1'b1;
                r.ep_act    = 1'b1;
                r.busy      = 1'b1;
            end
            SQ_LOCK: begin
                r.test_pd   = 1'b0;
                r.refclk_en = 1'b1;
                r.phy_rst   = 1'b0;
                r.busy      = 1'b1;
            end
            SQ_CORE: begin
                r.test_pd   = 1'b0;
                r.refclk_en = 1'b1;
                r.phy_rst   = 1'b0;
                r.core_rst  = 1'b0;
                r.busy      = 1'b1;
            end
            SQ_READY: begin
                r.test_pd   = 1'b0;
                r.refclk_en = 1'b1;
                r.phy_rst   = 1'b0;
                r.core_rst  = 1'b0;
                r.ready     = 1'b1;
            end
            SQ_FAIL: begin
                r.test_pd   = 1'b0;
                r.refclk_en = 1'b1;
                r.phy_rst   = 1'b0;
                r.err       = 1'b1;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/phy_pwrup_timer.sv
// Tick counter shared by all wait phases. It restarts on clr and wraps
// to zero when the limit is reached, so one instance also paces polls.
module phy_pwrup_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          done
);
    logic [TW-1:0] cnt_d, cnt_q;

    assign done = tick && (cnt_q == (limit - TW'(1)));

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (done) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/phy_pwrup_poll.sv
// Counts lock samples that came back negative.
module phy_pwrup_poll #(
    parameter int POLLS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int PW = (POLLS > 1) ? $clog2(POLLS) : 1;

    logic [PW-1:0] cnt_d, cnt_q;

    assign last = (cnt_q == PW'(POLLS - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && !last) begin
            cnt_d = cnt_q + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
    import phy_pwrup_pkg::*;
#(
    parameter int PD_TO_REFCLK_US  = 10,
    parameter int CLK_SETTLE_US    = 200,
    parameter int EP_HOLD_US       = 100,
    parameter int LOCK_POLL_GAP_US = 50,
    parameter int LOCK_POLL_MAX    = 2000,
    parameter int CORE_SETTLE_US   = 200,
    parameter bit EP_ACTIVE_HIGH   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic start,
    input  logic pwr_dn,
    input  logic pll_locked,
    output logic phy_test_pd,
    output logic core_rst,
    output logic refclk_en,
    output logic phy_rst,
    output logic ep_rst,
    output logic ready,
    output logic busy,
    output logic lock_err
);
    localparam int M1   = (PD_TO_REFCLK_US > CLK_SETTLE_US) ? PD_TO_REFCLK_US : CLK_SETTLE_US;
    localparam int M2   = (EP_HOLD_US > LOCK_POLL_GAP_US) ? EP_HOLD_US : LOCK_POLL_GAP_US;
    localparam int M3   = (M1 > M2) ? M1 : M2;
    localparam int TMAX = (M3 > CORE_SETTLE_US) ? M3 : CORE_SETTLE_US;
    localparam int TW   = $clog2(TMAX + 1);

    sq_regs_t  q, d;
    sq_state_e st_n;
    logic [TW-1:0] limit;
    logic t_done, t_clr, p_last, p_inc, p_clr;

    // Wait length of the current phase.
    always_comb begin
        case (q.st)
            SQ_PWRUP: limit = TW'(PD_TO_REFCLK_US);
            SQ_CLKON: limit = TW'(CLK_SETTLE_US);
            SQ_EPRST: limit = TW'(EP_HOLD_US);
            SQ_LOCK:  limit = TW'(LOCK_POLL_GAP_US);
            SQ_CORE:  limit = TW'(CORE_SETTLE_US);
            default:  limit = TW'(1);
        endcase
    end

    always_comb begin
        st_n = q.st;
        case (q.st)
            SQ_HOLD:  if (start)  st_n = SQ_PWRUP;
            SQ_PWRUP: if (t_done) st_n = SQ_CLKON;
            SQ_CLKON: if (t_done) st_n = SQ_EPRST;
            SQ_EPRST: if (t_done) st_n = SQ_LOCK;
            SQ_LOCK: begin
                if (t_done) begin
                    if (pll_locked) begin
                        st_n = SQ_CORE;
                    end else if (p_last) begin
                        st_n = SQ_FAIL;
                    end
                end
            end
            SQ_CORE:  if (t_done) st_n = SQ_READY;
            default: ;
        endcase
        if (pwr_dn) begin
            st_n = SQ_HOLD;
        end
        d = sq_decode(st_n);
    end

    assign t_clr = (st_n != q.st);
    assign p_clr = (q.st != SQ_LOCK);
    assign p_inc = (q.st == SQ_LOCK) && t_done && !pll_locked;

    phy_pwrup_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (t_clr),
        .tick  (tick_us),
        .limit (limit),
        .done  (t_done)
    );

    phy_pwrup_poll #(.POLLS(LOCK_POLL_MAX)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (p_clr),
        .inc   (p_inc),
        .last  (p_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= sq_decode(SQ_HOLD);
        end else begin
            q <= d;
        end
    end

    assign phy_test_pd = q.test_pd;
    assign core_rst    = q.core_rst;
    assign refclk_en   = q.refclk_en;
    assign phy_rst     = q.phy_rst;
    assign ready       = q.ready;
    assign busy        = q.busy;
    assign lock_err    = q.err;

    generate
        if (EP_ACTIVE_HIGH) begin : g_ep_hi
            assign ep_rst = q.ep_act;
        end else begin : g_ep_lo
            assign ep_rst = ~q.ep_act;
        end
    endgenerate
endmodule

// File: rtl/phy_pwrup_seq_chk.sv
module phy_pwrup_seq_chk #(
    parameter bit EP_ACTIVE_HIGH = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_dn,
    input logic phy_test_pd,
    input logic core_rst,
    input logic refclk_en,
    input logic phy_rst,
    input logic ep_rst,
    input logic ready,
    input logic busy,
    input logic lock_err
);
    p_hold_on_pwrdn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (phy_test_pd && core_rst && phy_rst && !refclk_en &&
                    !ready && !busy && !lock_err && (ep_rst == !EP_ACTIVE_HIGH)));

    p_refclk_after_pu_r2: assert property (@(posedge clk) disable iff (!rst_n)
        refclk_en |-> !phy_test_pd);

    p_ep_before_phy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst) |-> ($past(ep_rst) == EP_ACTIVE_HIGH && ep_rst == !EP_ACTIVE_HIGH));

    p_core_after_phy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst |-> !phy_rst);

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_err && !pwr_dn) |=> (lock_err && core_rst));

    p_status_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ready, busy, lock_err}));

    p_ready_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !pwr_dn) |=> (ready && !core_rst && refclk_en));
endmodule

bind phy_pwrup_seq phy_pwrup_seq_chk #(.EP_ACTIVE_HIGH(EP_ACTIVE_HIGH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_dn      (pwr_dn),
    .phy_test_pd (phy_test_pd),
    .core_rst    (core_rst),
    .refclk_en   (refclk_en),
    .phy_rst     (phy_rst),
    .ep_rst      (ep_rst),
    .ready       (ready),
    .busy        (busy),
    .lock_err    (lock_err)
);

// File: tb/phy_pwrup_seq_bench.sv
module phy_pwrup_seq_bench;
    localparam int PD   = 3;
    localparam int SET  = 5;
    localparam int EPH  = 4;
    localparam int GAP  = 3;
    localparam int PMAX = 4;
    localparam int CORE = 6;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0, pwr_dn = 1'b0, lock = 1'b0;
    logic pd_a, core_a, ref_a, phy_a, ep_a, rdy_a, busy_a, err_a;
    logic pd_b, core_b, ref_b, phy_b, ep_b, rdy_b, busy_b, err_b;

    int checks = 0, errors = 0, cyc = 0, wd = 0;
    int tick_div = 1, ticks = 0, lock_at = 0;
    bit lock_phase = 1'b0;

    always #5 clk = ~clk;

    phy_pwrup_seq #(.PD_TO_REFCLK_US(PD), .CLK_SETTLE_US(SET), .EP_HOLD_US(EPH),
        .LOCK_POLL_GAP_US(GAP), .LOCK_POLL_MAX(PMAX), .CORE_SETTLE_US(CORE),
        .EP_ACTIVE_HIGH(1'b1)) u_phy_pwrup_seq (
        .clk(clk), .rst_n(rst_n), .tick_us(tick), .start(start), .pwr_dn(pwr_dn),
        .pll_locked(lock), .phy_test_pd(pd_a), .core_rst(core_a), .refclk_en(ref_a),
        .phy_rst(phy_a), .ep_rst(ep_a), .ready(rdy_a), .busy(busy_a), .lock_err(err_a));

    phy_pwrup_seq #(.PD_TO_REFCLK_US(PD), .CLK_SETTLE_US(SET), .EP_HOLD_US(EPH),
        .LOCK_POLL_GAP_US(GAP), .LOCK_POLL_MAX(PMAX), .CORE_SETTLE_US(CORE),
        .EP_ACTIVE_HIGH(1'b0)) u_phy_pwrup_seq_lo (
        .clk(clk), .rst_n(rst_n), .tick_us(tick), .start(start), .pwr_dn(pwr_dn),
        .pll_locked(lock), .phy_test_pd(pd_b), .core_rst(core_b), .refclk_en(ref_b),
        .phy_rst(phy_b), .ep_rst(ep_b), .ready(rdy_b), .busy(busy_b), .lock_err(err_b));

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL R1 watchdog: actual %0d cycles expected fewer than 100000", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance to the next falling edge and count the tick the rising edge saw.
    task automatic step();
        @(negedge clk);
        ticks += int'(tick);
        cyc++;
    endtask

    // Drive inputs for the coming rising edge.
    task automatic drive();
        tick = ((cyc % tick_div) == 0);
        lock = lock_phase && (ticks >= lock_at);
    endtask

    task automatic cycle();
        step();
        drive();
    endtask

    function automatic bit held();
        return pd_a && core_a && !ref_a && phy_a && !ep_a && ep_b && !rdy_a && !busy_a && !err_a;
    endfunction

    task automatic run_seq(input int div, input int lth);
        int k, stage, n;
        bit to;
        tick_div   = div;
        lock_at    = lth;
        lock_phase = 1'b0;
        k  = (lth + GAP) / GAP;
        to = (k > PMAX);
        start = 1'b1;
        step();
        start = 1'b0;
        chk(!pd_a && busy_a && core_a && phy_a, "R2 start", int'(pd_a), 0);
        ticks = 0;
        drive();
        stage = 1;
        n = 0;
        while (stage < 6 && n < 600) begin
            step();
            start = 1'b0;
            n++;
            case (stage)
                1: if (ref_a) begin
                    chk(ticks == PD, "R2 refclk delay", ticks, PD);
                    ticks = 0; stage = 2;
                end
                2: if (ep_a) begin
                    chk(ticks == SET, "R3 settle", ticks, SET);
                    chk(ep_b == 1'b0, "R4 low polarity", int'(ep_b), 0);
                    ticks = 0; stage = 3;
                    start = 1'b1; // R9: start while busy must not disturb timing
                end
                3: if (!phy_a) begin
                    chk(ticks == EPH, "R4 ep hold (R9 start ignored)", ticks, EPH);
                    chk(!ep_a && ep_b, "R4 ep release", int'(ep_a), 0);
                    ticks = 0; lock_phase = 1'b1; stage = 4;
                end
                4: if (!core_a || err_a) begin
                    if (to) begin
                        chk(err_a && core_a && !busy_a && ticks == PMAX * GAP, "R6 timeout",
                            ticks, PMAX * GAP);
                        stage = 6;
                    end else begin
                        chk(!core_a && !err_a && ticks == k * GAP, "R5 lock poll", ticks, k * GAP);
                        stage = 5;
                    end
                    ticks = 0; lock_phase = 1'b0;
                end
                5: if (rdy_a) begin
                    chk(ticks == CORE && !busy_a && !core_a, "R7 ready", ticks, CORE);
                    stage = 6;
                end
                default: ;
            endcase
            drive();
        end
        chk(stage == 6, "R5 sequence completed", stage, 6);
        start = 1'b1;
        cycle();
        start = 1'b0;
        cycle();
        cycle();
        if (to) begin
            chk(err_a && !busy_a && !pd_a && core_a, "R6 error sticky, R9 start ignored",
                int'(err_a), 1);
        end else begin
            chk(rdy_a && !busy_a && !core_a, "R9 start ignored when ready", int'(rdy_a), 1);
        end
        pwr_dn = 1'b1;
        cycle();
        pwr_dn = 1'b0;
        chk(held(), "R8 power-down after run", int'(pd_a), 1);
        cycle();
    endtask

    initial begin
        drive();
        repeat (3) cycle();
        chk(held(), "R1 in reset", int'(pd_a), 1);
        rst_n = 1'b1;
        cycle();
        chk(held(), "R1 after reset", int'(busy_a), 0);
        for (int dv = 1; dv <= 3; dv++) begin
            run_seq(dv, 0);
            run_seq(dv, GAP - 1);
            run_seq(dv, GAP);
            run_seq(dv, PMAX * GAP - 1);
            run_seq(dv, PMAX * GAP);
        end
        // Power-down sweep over every phase, with start asserted alongside.
        tick_div   = 1;
        lock_at    = 0;
        lock_phase = 1'b1;
        for (int n = 1; n <= 30; n++) begin
            start = 1'b1;
            cycle();
            start = 1'b0;
            repeat (n) cycle();
            pwr_dn = 1'b1;
            start  = 1'b1;
            cycle();
            chk(held(), "R8 power-down priority", n, 0);
            pwr_dn = 1'b0;
            start  = 1'b0;
            cycle();
            chk(held(), "R8 stays held", n, 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule